// File: doc/BRIEF.md
# Coherent Child Cache Controller

This block is the child-side half of an MSI directory coherence protocol for one first-level cache. It keeps three things for each line of a small direct-indexed array: a coherence state (Invalid, Shared or Modified), a flag that marks a line waiting on the parent, and the line data. The index used to address a line is the full line address; there is no tag compare and no replacement policy.

It talks to the parent over two message channels. The child-to-parent channel carries upgrade requests and downgrade responses. The parent-to-child channel carries downgrade requests and upgrade responses. Each message holds a command (request or response), the child identity, a line address, a target state, a data-present bit and the line data. On the processor side, a read needs Shared or better and a write needs Modified. A processor access with enough rights completes locally. An access without enough rights raises an upgrade request and waits for the parent. An external evict strobe requests a voluntary downgrade of a chosen line to a chosen state.

Each cycle the block takes at most one action. Parent messages go first, then evicts, then the processor. Upgrade responses are always consumed. Any action that sends a message needs the single outgoing message slot to be free, or to be draining in the same cycle.

Top module: `coh_child_ctrl`

## Requirements
- R1: After reset every line is Invalid with its wait flag clear, and neither `c2mValid` nor `procRespValid` is asserted.
- R2: State codes are I=0, S=1, M=2, ordered so that a larger code carries more rights. A processor read is accepted (`procReqReady`=1) when the line state is S or M. A write is accepted only in M. The cycle after acceptance, `procRespValid` is 1 and `procRespData` holds the line data for a read, or the newly written data for a write, which also replaces the line data.
- R3: A processor access that lacks rights on a line whose wait flag is clear loads an upgrade request. That request has `c2mIsResp`=0, `c2mState` S for a read or M for a write, `c2mHasData`=0, and the access address. The same action sets the line's wait flag. While the flag is set, no further request is sent for that line.
- R4: A parent message with `m2cIsResp`=1 is always accepted in the same cycle. It sets the line state to `m2cState`, writes `m2cData` into the line only when `m2cHasData`=1, and clears the wait flag.
- R5: A parent downgrade request (`m2cIsResp`=0) to state y, finding the line above y, sends a response with `c2mIsResp`=1, `c2mState`=y and the same address, and lowers the line to y.
- R6: A downgrade response, whether voluntary or requested, has `c2mHasData`=1 and carries the line data exactly when the line was in M before the downgrade. Otherwise `c2mHasData`=0.
- R7: A parent downgrade request to y, finding the line already at or below y, is dequeued with no message sent and no change of state.
- R8: An evict to y is taken (`evictReady`=1) when no parent message is present and the outgoing slot is free. It sends a downgrade response and lowers the line only if the line's wait flag is clear and its state is above y; otherwise it has no effect. A downgrade from S to I is reported like any other.
- R9: While `c2mValid`=1 and `c2mReady`=0, the outgoing message and all its fields stay unchanged. `c2mSrc` always equals the `CHILD_ID` parameter.
- R10: Parent messages take priority over evicts, and evicts over processor accesses. A parent downgrade request is not accepted while the outgoing slot is full and not draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| procReqValid | input | 1 | Processor access present |
| procReqReady | output | 1 | Processor access completes this cycle |
| procReqWrite | input | 1 | 1 = write, 0 = read |
| procReqAddr | input | ADDR_W | Line index of the access |
| procReqData | input | DATA_W | Write data (whole line) |
| procRespValid | output | 1 | Access completion, one cycle after acceptance |
| procRespData | output | DATA_W | Read data or written data |
| evictValid | input | 1 | Voluntary downgrade strobe |
| evictReady | output | 1 | Evict strobe consumed this cycle |
| evictAddr | input | ADDR_W | Line to downgrade |
| evictTarget | input | 2 | Target state code |
| m2cValid | input | 1 | Parent message present |
| m2cReady | output | 1 | Parent message dequeued this cycle |
| m2cIsResp | input | 1 | 1 = upgrade response, 0 = downgrade request |
| m2cAddr | input | ADDR_W | Line index |
| m2cState | input | 2 | Target state code |
| m2cHasData | input | 1 | Data field is valid |
| m2cData | input | DATA_W | Line data |
| c2mValid | output | 1 | Outgoing message present |
| c2mReady | input | 1 | Parent takes the outgoing message |
| c2mIsResp | output | 1 | 1 = downgrade response, 0 = upgrade request |
| c2mSrc | output | ID_W | Child identity |
| c2mAddr | output | ADDR_W | Line index |
| c2mState | output | 2 | Target state code |
| c2mHasData | output | 1 | Data field is valid |
| c2mData | output | DATA_W | Line data |

## Verification
The bench plays the parent and keeps its own copy of every line's state, wait flag and data. The hardest corner is a downgrade request that lands on a line a voluntary evict has already lowered. A design that answered it anyway would send a stray response, and one that lowered the state further would lose rights it still holds. Other targeted cases are an evict attempted while the line waits on an upgrade (a wrong design sends a downgrade the parent cannot match), an S-to-I evict (a design that drops it silently leaves the directory stale), and data attached only when leaving M (a wrong design leaks or loses dirty data). A parent request arriving while the outgoing slot is stalled checks the priority and hold rules: a faulty design would overwrite the pending request or dequeue a message it cannot answer.

// File: rtl/coh_child_pkg.sv
package coh_child_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PAR   = 2'd1,
    SEL_EVICT = 2'd2,
    SEL_PROC  = 2'd3
  } addrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    addrSel_t   sel;
    logic       writeState;
    lineState_t newState;
    logic       setWait;
    logic       clrWait;
    logic       loadParData;
    logic       loadProcData;
    logic       loadOut;
    logic       outIsResp;
    lineState_t outState;
    logic       outWithData;
    logic       procAccept;
  } ctlStrobe_t;

endpackage

// File: rtl/coh_child_fsm.sv
module coh_child_fsm
  import coh_child_pkg::*;
(
  input  logic       m2cValid,
  input  logic       m2cIsResp,
  input  logic [1:0] m2cState,
  input  logic       m2cHasData,
  input  lineState_t parLineState,
  input  logic       evictValid,
  input  logic [1:0] evictTarget,
  input  lineState_t evLineState,
  input  logic       evLineWait,
  input  logic       procReqValid,
  input  logic       procReqWrite,
  input  lineState_t procLineState,
  input  logic       procLineWait,
  input  logic       c2mValid,
  input  logic       c2mReady,
  output logic       m2cReady,
  output logic       evictReady,
  output logic       procReqReady,
  output ctlStrobe_t strobe
);

  logic       outFree;
  lineState_t parTarget;
  lineState_t evTarget;
  lineState_t needState;

  assign outFree   = !c2mValid || c2mReady;
  assign parTarget = lineState_t'(m2cState);
  assign evTarget  = lineState_t'(evictTarget);
  assign needState = procReqWrite ? LS_M : LS_S;

  always_comb begin
    strobe       = '0;
    m2cReady     = 1'b0;
    evictReady   = 1'b0;
    procReqReady = 1'b0;

    if (m2cValid) begin
      if (m2cIsResp) begin
        // upgrade responses always drain
        m2cReady           = 1'b1;
        strobe.sel         = SEL_PAR;
        strobe.writeState  = 1'b1;
        strobe.newState    = parTarget;
        strobe.clrWait     = 1'b1;
        strobe.loadParData = m2cHasData;
      end else if (outFree) begin
        m2cReady = 1'b1;
        if (parLineState > parTarget) begin
          strobe.sel         = SEL_PAR;
          strobe.writeState  = 1'b1;
          strobe.newState    = parTarget;
          strobe.loadOut     = 1'b1;
          strobe.outIsResp   = 1'b1;
          strobe.outState    = parTarget;
          strobe.outWithData = (parLineState == LS_M);
        end
      end
    end else if (evictValid && outFree) begin
      evictReady = 1'b1;
      if (!evLineWait && (evLineState > evTarget)) begin
        strobe.sel         = SEL_EVICT;
        strobe.writeState  = 1'b1;
        strobe.newState    = evTarget;
        strobe.loadOut     = 1'b1;
        strobe.outIsResp   = 1'b1;
        strobe.outState    = evTarget;
        strobe.outWithData = (evLineState == LS_M);
      end
    end else if (procReqValid) begin
      if (procLineState >= needState) begin
        procReqReady        = 1'b1;
        strobe.sel          = SEL_PROC;
        strobe.procAccept   = 1'b1;
        strobe.loadProcData = procReqWrite;
      end else if (!procLineWait && outFree) begin
        strobe.sel       = SEL_PROC;
        strobe.loadOut   = 1'b1;
        strobe.outIsResp = 1'b0;
        strobe.outState  = needState;
        strobe.setWait   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/coh_child_dp.sv
module coh_child_dp
  import coh_child_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int CHILD_ID = 3,
  localparam int ADDR_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] m2cAddr,
  input  logic [DATA_W-1:0] m2cData,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [DATA_W-1:0] procData,
  input  logic              c2mReady,
  output lineState_t        parLineState,
  output lineState_t        evLineState,
  output logic              evLineWait,
  output lineState_t        procLineState,
  output logic              procLineWait,
  output logic              c2mValid,
  output logic              c2mIsResp,
  output logic [ID_W-1:0]   c2mSrc,
  output logic [ADDR_W-1:0] c2mAddr,
  output lineState_t        c2mState,
  output logic              c2mHasData,
  output logic [DATA_W-1:0] c2mData,
  output logic              procRespValid,
  output logic [DATA_W-1:0] procRespData
);

  lineState_t        stateArr [LINES];
  logic              waitArr  [LINES];
  logic [DATA_W-1:0] dataArr  [LINES];
  logic [ADDR_W-1:0] selAddr;

  always_comb begin
    unique case (strobe.sel)
      SEL_PAR:   selAddr = m2cAddr;
      SEL_EVICT: selAddr = evictAddr;
      SEL_PROC:  selAddr = procAddr;
      default:   selAddr = '0;
    endcase
  end

  assign parLineState  = stateArr[m2cAddr];
  assign evLineState   = stateArr[evictAddr];
  assign evLineWait    = waitArr[evictAddr];
  assign procLineState = stateArr[procAddr];
  assign procLineWait  = waitArr[procAddr];
  assign c2mSrc        = ID_W'(CHILD_ID);

  // per-line state, wait flag and data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        stateArr[i] <= LS_I;
        waitArr[i]  <= 1'b0;
        dataArr[i]  <= '0;
      end
    end else begin
      if (strobe.writeState) stateArr[selAddr] <= strobe.newState;
      if (strobe.setWait)    waitArr[selAddr]  <= 1'b1;
      else if (strobe.clrWait) waitArr[selAddr] <= 1'b0;
      if (strobe.loadParData)       dataArr[selAddr] <= m2cData;
      else if (strobe.loadProcData) dataArr[selAddr] <= procData;
    end
  end

  // single outgoing message slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c2mValid   <= 1'b0;
      c2mIsResp  <= 1'b0;
      c2mAddr    <= '0;
      c2mState   <= LS_I;
      c2mHasData <= 1'b0;
      c2mData    <= '0;
    end else if (strobe.loadOut) begin
      c2mValid   <= 1'b1;
      c2mIsResp  <= strobe.outIsResp;
      c2mAddr    <= selAddr;
      c2mState   <= strobe.outState;
      c2mHasData <= strobe.outWithData;
      c2mData    <= strobe.outWithData ? dataArr[selAddr] : '0;
    end else if (c2mReady) begin
      c2mValid <= 1'b0;
    end
  end

  // processor completion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      procRespValid <= 1'b0;
      procRespData  <= '0;
    end else begin
      procRespValid <= strobe.procAccept;
      if (strobe.procAccept)
        procRespData <= strobe.loadProcData ? procData : dataArr[procAddr];
    end
  end

endmodule

// File: rtl/coh_child_ctrl.sv
module coh_child_ctrl
  import coh_child_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int CHILD_ID = 3,
  localparam int ADDR_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              procReqValid,
  output logic              procReqReady,
  input  logic              procReqWrite,
  input  logic [ADDR_W-1:0] procReqAddr,
  input  logic [DATA_W-1:0] procReqData,
  output logic              procRespValid,
  output logic [DATA_W-1:0] procRespData,
  input  logic              evictValid,
  output logic              evictReady,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [1:0]        evictTarget,
  input  logic              m2cValid,
  output logic              m2cReady,
  input  logic              m2cIsResp,
  input  logic [ADDR_W-1:0] m2cAddr,
  input  logic [1:0]        m2cState,
  input  logic              m2cHasData,
  input  logic [DATA_W-1:0] m2cData,
  output logic              c2mValid,
  input  logic              c2mReady,
  output logic              c2mIsResp,
  output logic [ID_W-1:0]   c2mSrc,
  output logic [ADDR_W-1:0] c2mAddr,
  output logic [1:0]        c2mState,
  output logic              c2mHasData,
  output logic [DATA_W-1:0] c2mData
);

  ctlStrobe_t strobe;
  lineState_t parLineState;
  lineState_t evLineState;
  lineState_t procLineState;
  lineState_t outState;
  logic       evLineWait;
  logic       procLineWait;

  assign c2mState = outState;

  coh_child_fsm u_fsm (
    .m2cValid     (m2cValid),
    .m2cIsResp    (m2cIsResp),
    .m2cState     (m2cState),
    .m2cHasData   (m2cHasData),
    .parLineState (parLineState),
    .evictValid   (evictValid),
    .evictTarget  (evictTarget),
    .evLineState  (evLineState),
    .evLineWait   (evLineWait),
    .procReqValid (procReqValid),
    .procReqWrite (procReqWrite),
    .procLineState(procLineState),
    .procLineWait (procLineWait),
    .c2mValid     (c2mValid),
    .c2mReady     (c2mReady),
    .m2cReady     (m2cReady),
    .evictReady   (evictReady),
    .procReqReady (procReqReady),
    .strobe       (strobe)
  );

  coh_child_dp #(
    .LINES   (LINES),
    .DATA_W  (DATA_W),
    .ID_W    (ID_W),
    .CHILD_ID(CHILD_ID)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .m2cAddr      (m2cAddr),
    .m2cData      (m2cData),
    .evictAddr    (evictAddr),
    .procAddr     (procReqAddr),
    .procData     (procReqData),
    .c2mReady     (c2mReady),
    .parLineState (parLineState),
    .evLineState  (evLineState),
    .evLineWait   (evLineWait),
    .procLineState(procLineState),
    .procLineWait (procLineWait),
    .c2mValid     (c2mValid),
    .c2mIsResp    (c2mIsResp),
    .c2mSrc       (c2mSrc),
    .c2mAddr      (c2mAddr),
    .c2mState     (outState),
    .c2mHasData   (c2mHasData),
    .c2mData      (c2mData),
    .procRespValid(procRespValid),
    .procRespData (procRespData)
  );

endmodule

// File: rtl/coh_child_chk.sv
module coh_child_chk #(
  parameter int ADDR_W   = 3,
  parameter int ID_W     = 4,
  parameter int CHILD_ID = 3,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              procReqValid,
  input logic              procReqReady,
  input logic              procRespValid,
  input logic              evictValid,
  input logic              evictReady,
  input logic [ADDR_W-1:0] evictAddr,
  input logic [1:0]        evictTarget,
  input logic              m2cValid,
  input logic              m2cReady,
  input logic              m2cIsResp,
  input logic [ADDR_W-1:0] m2cAddr,
  input logic [1:0]        m2cState,
  input logic              c2mValid,
  input logic              c2mReady,
  input logic              c2mIsResp,
  input logic [ID_W-1:0]   c2mSrc,
  input logic [ADDR_W-1:0] c2mAddr,
  input logic [1:0]        c2mState,
  input logic              c2mHasData,
  input logic [DATA_W-1:0] c2mData
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c2mValid && !c2mReady) |=> (c2mValid && $stable(c2mIsResp) && $stable(c2mAddr)
      && $stable(c2mState) && $stable(c2mHasData) && $stable(c2mData)));

  assert_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c2mValid |-> (c2mSrc == ID_W'(CHILD_ID)));

  assert_resp_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m2cValid && m2cIsResp) |-> m2cReady);

  assert_req_fmt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c2mValid && !c2mIsResp) |-> (!c2mHasData && (c2mState == 2'd1 || c2mState == 2'd2)));

  assert_down_fmt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c2mValid && c2mIsResp) |-> (c2mState != 2'd2));

  assert_par_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m2cValid && m2cReady && !m2cIsResp) |=>
      (!c2mValid || (c2mIsResp && c2mState == $past(m2cState) && c2mAddr == $past(m2cAddr))));

  assert_evict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evictValid && evictReady) |=>
      (!c2mValid || (c2mIsResp && c2mState == $past(evictTarget) && c2mAddr == $past(evictAddr))));

  assert_prio_evict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m2cValid |-> !evictReady);

  assert_prio_proc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m2cValid || (evictValid && evictReady)) |-> !procReqReady);

  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m2cValid && !m2cIsResp && c2mValid && !c2mReady) |-> !m2cReady);

  assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (procReqValid && procReqReady) |=> procRespValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(procReqValid && procReqReady) |=> !procRespValid);

endmodule

bind coh_child_ctrl coh_child_chk #(
  .ADDR_W  (ADDR_W),
  .ID_W    (ID_W),
  .CHILD_ID(CHILD_ID),
  .DATA_W  (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .procReqValid (procReqValid),
  .procReqReady (procReqReady),
  .procRespValid(procRespValid),
  .evictValid   (evictValid),
  .evictReady   (evictReady),
  .evictAddr    (evictAddr),
  .evictTarget  (evictTarget),
  .m2cValid     (m2cValid),
  .m2cReady     (m2cReady),
  .m2cIsResp    (m2cIsResp),
  .m2cAddr      (m2cAddr),
  .m2cState     (m2cState),
  .c2mValid     (c2mValid),
  .c2mReady     (c2mReady),
  .c2mIsResp    (c2mIsResp),
  .c2mSrc       (c2mSrc),
  .c2mAddr      (c2mAddr),
  .c2mState     (c2mState),
  .c2mHasData   (c2mHasData),
  .c2mData      (c2mData)
);

// File: tb/coh_child_ctrl_bench.sv
module coh_child_ctrl_bench;

  localparam int LINES    = 8;
  localparam int DATA_W   = 32;
  localparam int ID_W     = 4;
  localparam int CHILD_ID = 3;
  localparam int ADDR_W   = $clog2(LINES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              procReqValid = 1'b0;
  logic              procReqReady;
  logic              procReqWrite = 1'b0;
  logic [ADDR_W-1:0] procReqAddr = '0;
  logic [DATA_W-1:0] procReqData = '0;
  logic              procRespValid;
  logic [DATA_W-1:0] procRespData;
  logic              evictValid = 1'b0;
  logic              evictReady;
  logic [ADDR_W-1:0] evictAddr = '0;
  logic [1:0]        evictTarget = '0;
  logic              m2cValid = 1'b0;
  logic              m2cReady;
  logic              m2cIsResp = 1'b0;
  logic [ADDR_W-1:0] m2cAddr = '0;
  logic [1:0]        m2cState = '0;
  logic              m2cHasData = 1'b0;
  logic [DATA_W-1:0] m2cData = '0;
  logic              c2mValid;
  logic              c2mReady = 1'b0;
  logic              c2mIsResp;
  logic [ID_W-1:0]   c2mSrc;
  logic [ADDR_W-1:0] c2mAddr;
  logic [1:0]        c2mState;
  logic              c2mHasData;
  logic [DATA_W-1:0] c2mData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [1:0]        mState [LINES];
  logic              mWait  [LINES];
  logic [DATA_W-1:0] mData  [LINES];

  always #10 clk = ~clk;

  coh_child_ctrl #(
    .LINES(LINES), .DATA_W(DATA_W), .ID_W(ID_W), .CHILD_ID(CHILD_ID)
  ) u_coh_child_ctrl (
    .clk(clk), .rst_n(rst_n),
    .procReqValid(procReqValid), .procReqReady(procReqReady),
    .procReqWrite(procReqWrite), .procReqAddr(procReqAddr),
    .procReqData(procReqData), .procRespValid(procRespValid),
    .procRespData(procRespData),
    .evictValid(evictValid), .evictReady(evictReady),
    .evictAddr(evictAddr), .evictTarget(evictTarget),
    .m2cValid(m2cValid), .m2cReady(m2cReady), .m2cIsResp(m2cIsResp),
    .m2cAddr(m2cAddr), .m2cState(m2cState), .m2cHasData(m2cHasData),
    .m2cData(m2cData),
    .c2mValid(c2mValid), .c2mReady(c2mReady), .c2mIsResp(c2mIsResp),
    .c2mSrc(c2mSrc), .c2mAddr(c2mAddr), .c2mState(c2mState),
    .c2mHasData(c2mHasData), .c2mData(c2mData)
  );

  function automatic logic [1:0] needOf(input logic wr);
    return wr ? 2'd2 : 2'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic popOut;
    c2mReady = 1'b1;
    step();
    c2mReady = 1'b0;
  endtask

  task automatic checkDownResp(input int idx, input logic [1:0] y,
                               input logic [1:0] oldSt, input string tag);
    chk(c2mValid && c2mIsResp, {tag, " response sent"}, {c2mValid, c2mIsResp}, 2'b11);
    chk(c2mState == y && c2mAddr == ADDR_W'(idx), {tag, " state/addr"},
        {c2mState, c2mAddr}, {y, ADDR_W'(idx)});
    chk(c2mSrc == ID_W'(CHILD_ID), "R9 source id", c2mSrc, CHILD_ID);
    chk(c2mHasData == (oldSt == 2'd2), "R6 data flag", c2mHasData, oldSt == 2'd2);
    if (oldSt == 2'd2)
      chk(c2mData == mData[idx], "R6 dirty data", c2mData, mData[idx]);
  endtask

  // parent answers an upgrade request
  task automatic sendUpgrade(input int idx, input logic [1:0] st);
    logic [DATA_W-1:0] d;
    logic hd;
    d  = $urandom;
    hd = (mState[idx] == 2'd0);
    m2cValid = 1'b1; m2cIsResp = 1'b1; m2cAddr = ADDR_W'(idx);
    m2cState = st; m2cHasData = hd; m2cData = d;
    #1;
    chk(m2cReady, "R4 response accepted", m2cReady, 1);
    step();
    m2cValid = 1'b0;
    mState[idx] = st;
    mWait[idx]  = 1'b0;
    if (hd) mData[idx] = d;
  endtask

  task automatic procAccess(input logic wr, input int idx, input logic [DATA_W-1:0] d);
    logic [1:0] need;
    bit done;
    need = needOf(wr);
    done = 0;
    procReqValid = 1'b1; procReqWrite = wr;
    procReqAddr = ADDR_W'(idx); procReqData = d;
    for (int it = 0; it < 8 && !done; it++) begin
      #1;
      if (procReqReady) begin
        chk(mState[idx] >= need, "R2 hit only with rights", mState[idx], need);
        step();
        procReqValid = 1'b0;
        chk(procRespValid, "R2 completion next cycle", procRespValid, 1);
        if (wr) mData[idx] = d;
        chk(procRespData == mData[idx], "R2 completion data", procRespData, mData[idx]);
        done = 1;
      end else begin
        chk(mState[idx] < need, "R2 miss only without rights", mState[idx], need);
        step();
        chk(c2mValid && !c2mIsResp, "R3 upgrade request", {c2mValid, c2mIsResp}, 2'b10);
        chk(c2mState == need && c2mAddr == ADDR_W'(idx) && !c2mHasData,
            "R3 request fields", {c2mState, c2mAddr, c2mHasData},
            {need, ADDR_W'(idx), 1'b0});
        mWait[idx] = 1'b1;
        popOut();
        chk(!c2mValid, "R3 no repeat while waiting", c2mValid, 0);
        sendUpgrade(idx, need);
      end
    end
    procReqValid = 1'b0;
    if (!done) chk(0, "R2 access never completed", 0, 1);
  endtask

  task automatic parentDown(input int idx, input logic [1:0] y);
    logic [1:0] old;
    old = mState[idx];
    m2cValid = 1'b1; m2cIsResp = 1'b0; m2cAddr = ADDR_W'(idx);
    m2cState = y; m2cHasData = 1'b0;
    #1;
    chk(m2cReady, "R10 request taken when slot free", m2cReady, 1);
    step();
    m2cValid = 1'b0;
    if (old > y) begin
      checkDownResp(idx, y, old, "R5");
      popOut();
      mState[idx] = y;
    end else begin
      chk(!c2mValid, "R7 dropped with no response", c2mValid, 0);
    end
  endtask

  task automatic evictDo(input int idx, input logic [1:0] y);
    logic [1:0] old;
    old = mState[idx];
    evictValid = 1'b1; evictAddr = ADDR_W'(idx); evictTarget = y;
    #1;
    chk(evictReady, "R8 evict taken", evictReady, 1);
    step();
    evictValid = 1'b0;
    if (!mWait[idx] && old > y) begin
      checkDownResp(idx, y, old, "R8");
      popOut();
      mState[idx] = y;
    end else begin
      chk(!c2mValid, "R8 evict ignored", c2mValid, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      mState[i] = 2'd0; mWait[i] = 1'b0; mData[i] = '0;
    end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!c2mValid, "R1 no outgoing after reset", c2mValid, 0);
    chk(!procRespValid, "R1 no completion after reset", procRespValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!c2mValid && !procRespValid, "R1 idle after reset", {c2mValid, procRespValid}, 0);
    // R1: a read on a fresh line misses
    procReqValid = 1'b1; procReqWrite = 1'b0; procReqAddr = '0;
    #1;
    chk(!procReqReady, "R1 line invalid after reset", procReqReady, 0);
    procReqValid = 1'b0;

    // R7: downgrade requests that find the line low enough
    procAccess(1'b0, 1, 32'h1111_0001);
    parentDown(1, 2'd1);
    parentDown(1, 2'd2);
    parentDown(1, 2'd0);
    parentDown(1, 2'd0);

    // R6: dirty data leaves with the M->S downgrade
    procAccess(1'b1, 2, 32'hCAFE_0002);
    parentDown(2, 2'd1);
    procAccess(1'b0, 2, 32'h0);
    // R8: S->I evict is reported, a second one is ignored
    evictDo(2, 2'd0);
    evictDo(2, 2'd0);
    // R7 after voluntary downgrade: parent asks for what is already done
    procAccess(1'b1, 5, 32'h5555_0005);
    evictDo(5, 2'd1);
    parentDown(5, 2'd1);
    parentDown(5, 2'd0);

    // R8 / R3: evict while waiting on an upgrade is ignored
    procAccess(1'b0, 3, 32'h0);
    procReqValid = 1'b1; procReqWrite = 1'b1; procReqAddr = 3'd3; procReqData = 32'hBEEF_0003;
    #1;
    chk(!procReqReady, "R2 write needs M", procReqReady, 0);
    step();
    chk(c2mValid && c2mState == 2'd2, "R3 upgrade to M", {c2mValid, c2mState}, 3'b110);
    popOut();
    mWait[3] = 1'b1;
    evictDo(3, 2'd0);
    step();
    chk(!c2mValid, "R3 single request while waiting", c2mValid, 0);
    sendUpgrade(3, 2'd2);
    #1;
    chk(procReqReady, "R4 state installed, write proceeds", procReqReady, 1);
    step();
    procReqValid = 1'b0;
    mData[3] = 32'hBEEF_0003;
    chk(procRespValid && procRespData == mData[3], "R2 write completion",
        procRespData, mData[3]);

    // R10 / R9: parent request while outgoing slot stalled
    procReqValid = 1'b1; procReqWrite = 1'b0; procReqAddr = 3'd4;
    step();
    chk(c2mValid && c2mAddr == 3'd4, "R3 request for line 4", c2mAddr, 4);
    mWait[4] = 1'b1;
    m2cValid = 1'b1; m2cIsResp = 1'b0; m2cAddr = 3'd3; m2cState = 2'd1;
    #1;
    chk(!m2cReady, "R10 request blocked by full slot", m2cReady, 0);
    step();
    step();
    chk(c2mValid && !c2mIsResp && c2mAddr == 3'd4 && c2mState == 2'd1,
        "R9 stalled message held", {c2mIsResp, c2mAddr, c2mState}, {1'b0, 3'd4, 2'd1});
    c2mReady = 1'b1;
    #1;
    chk(m2cReady, "R10 taken while slot drains", m2cReady, 1);
    step();
    c2mReady = 1'b0;
    m2cValid = 1'b0;
    checkDownResp(3, 2'd1, 2'd2, "R5");
    popOut();
    mState[3] = 2'd1;
    sendUpgrade(4, 2'd1);
    #1;
    chk(procReqReady, "R4 read proceeds after upgrade", procReqReady, 1);
    step();
    procReqValid = 1'b0;
    chk(procRespData == mData[4], "R4 installed data read back", procRespData, mData[4]);

    // R10: evict outranks processor
    procReqValid = 1'b1; procReqWrite = 1'b0; procReqAddr = 3'd4;
    evictValid = 1'b1; evictAddr = 3'd6; evictTarget = 2'd0;
    #1;
    chk(evictReady && !procReqReady, "R10 evict before processor",
        {evictReady, procReqReady}, 2'b10);
    step();
    evictValid = 1'b0;
    chk(!c2mValid, "R8 evict of invalid line ignored", c2mValid, 0);
    procReqValid = 1'b0;
    step();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      int idx;
      op  = int'($urandom_range(0, 3));
      idx = int'($urandom_range(0, LINES - 1));
      case (op)
        0: procAccess(1'b0, idx, 32'h0);
        1: procAccess(1'b1, idx, $urandom);
        2: parentDown(idx, 2'($urandom_range(0, 2)));
        default: evictDo(idx, 2'($urandom_range(0, 1)));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

endmodule